// File: doc/BRIEF.md
# Tagged Byte-Stream CRC-32 Engine

This block computes the Ethernet CRC-32 over a packet payload that arrives as bytes, one byte per clock. Each accepted byte goes through the reflected, LSB-first update: the byte is folded into the low end of the 32-bit register, and the register then takes eight right-shift steps with the constant 0xEDB88320. All eight steps are unrolled into combinational logic, so the engine never stalls and takes a byte on every cycle that the input valid strobe is high.

Each byte carries markers for the start and the end of its packet. The start marker replaces the running register with the all-ones seed in the same cycle, so one packet can follow another with no idle cycle between them. The packet identifier is taken from the first byte. One cycle after the closing byte is accepted, the engine presents the complemented register and that identifier for a single cycle. A downstream checker can use the identifier to pair results that reach it out of order.

Top module: `crc32_tagged_engine`

## Requirements
- R1: A byte with `in_first` high and `in_valid` high is updated starting from 0xFFFFFFFF, whatever the register held before.
- R2: Each accepted byte is XORed into register bits 7:0. The register then takes eight steps, each shifting right by one and XORing in 0xEDB88320 when the bit shifted out was 1. Over the ASCII bytes "123456789" this gives 0xCBF43926.
- R3: The reported CRC is the bitwise complement of the register after the closing byte. A lone byte 0x00 reports 0xD202EF8D.
- R4: A byte is accepted on every cycle with `in_valid` high, with no stall. Packets sent back to back with no idle cycle each give their own correct CRC.
- R5: `res_valid` is high for exactly one cycle, the cycle after a byte with `in_valid` and `in_last` both high. It is low at all other times.
- R6: `res_id` equals the `in_id` sampled on the packet's first byte. `in_id` on later bytes has no effect.
- R7: A packet of one byte, with `in_first` and `in_last` both high, gives the correct CRC and its own ID.
- R8: While `in_valid` is low, `in_data` and the markers have no effect on the register or on any result.
- R9: Synchronous active-high `rst` clears `res_valid` and loads the register with 0xFFFFFFFF. A packet sent right after reset without a start marker therefore gives the standard CRC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte strobe |
| in_first | input | 1 | Marks the first byte of a packet |
| in_last | input | 1 | Marks the last byte of a packet |
| in_data | input | 8 | Payload byte |
| in_id | input | ID_W (8) | Packet identifier, sampled on the first byte |
| res_valid | output | 1 | One-cycle strobe for a finished CRC |
| res_crc | output | 32 | Finished, complemented CRC |
| res_id | output | ID_W (8) | Identifier of the packet the CRC belongs to |

## Verification
The check string "123456789" and the lone zero byte have fixed known answers. They separate a wrong constant, a wrong shift direction, a missing seed or a missing final complement. The same string sent with idle gaps carrying junk data and junk markers shows that bytes without the strobe are ignored. A packet sent right after reset without a start marker shows that reset seeds the register. A run of four packets of mixed length sent back to back, including a one-byte packet, tests the start-marker seed override, the per-packet ID capture and the one-cycle result timing against a bit-serial model kept in the bench.

// File: rtl/crc32_eng_pkg.sv
package crc32_eng_pkg;
   localparam int unsigned    CRC_W_DEF = 32;
   localparam int unsigned    BYTE_W    = 8;
   localparam logic [31:0]    POLY_REFL = 32'hEDB88320;
   localparam logic [31:0]    SEED_ONES = 32'hFFFFFFFF;

   typedef enum logic [0:0] {
      FIN_PLAIN  = 1'b0,
      FIN_INVERT = 1'b1
   } fin_mode_e;
endpackage

// File: rtl/crc_shift_step.sv
module crc_shift_step #(
   parameter int unsigned       W    = 32,
   parameter logic [W-1:0]      POLY = '1
) (
   input  logic [W-1:0] s_in,
   output logic [W-1:0] s_out
);
   logic [W-1:0] shifted;
   assign shifted = s_in >> 1;
   assign s_out   = s_in[0] ? (shifted ^ POLY) : shifted;
endmodule

// File: rtl/crc_byte_update.sv
module crc_byte_update #(
   parameter int unsigned       W    = 32,
   parameter int unsigned       DW   = 8,
   parameter logic [W-1:0]      POLY = '1
) (
   input  logic [W-1:0]  crc_in,
   input  logic [DW-1:0] data,
   output logic [W-1:0]  crc_out
);
   localparam int unsigned STEPS = DW;

   if (DW > W) begin : g_bad_width
      $error("crc_byte_update: data width exceeds register width");
   end

   logic [W-1:0] chain [0:STEPS];

   assign chain[0] = crc_in ^ W'(data);

   for (genvar k = 0; k < STEPS; k++) begin : g_step
      crc_shift_step #(.W(W), .POLY(POLY)) u_step (
         .s_in  (chain[k]),
         .s_out (chain[k+1])
      );
   end

   assign crc_out = chain[STEPS];
endmodule

// File: rtl/crc_finalize.sv
module crc_finalize #(
   parameter int unsigned                  W    = 32,
   parameter crc32_eng_pkg::fin_mode_e     MODE = crc32_eng_pkg::FIN_INVERT
) (
   input  logic [W-1:0] raw,
   output logic [W-1:0] fin
);
   if (MODE == crc32_eng_pkg::FIN_INVERT) begin : g_inv
      assign fin = ~raw;
   end else begin : g_plain
      assign fin = raw;
   end
endmodule

// File: rtl/crc32_tagged_engine.sv
module crc32_tagged_engine #(
   parameter int unsigned                CRC_W = crc32_eng_pkg::CRC_W_DEF,
   parameter int unsigned                DATA_W = crc32_eng_pkg::BYTE_W,
   parameter int unsigned                ID_W  = 8,
   parameter logic [CRC_W-1:0]           POLY  = crc32_eng_pkg::POLY_REFL,
   parameter logic [CRC_W-1:0]           SEED  = crc32_eng_pkg::SEED_ONES,
   parameter crc32_eng_pkg::fin_mode_e   FIN   = crc32_eng_pkg::FIN_INVERT
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic              in_first,
   input  logic              in_last,
   input  logic [DATA_W-1:0] in_data,
   input  logic [ID_W-1:0]   in_id,
   output logic              res_valid,
   output logic [CRC_W-1:0]  res_crc,
   output logic [ID_W-1:0]   res_id
);
   localparam int unsigned MIN_ID_W = 1;

   if (ID_W < MIN_ID_W) begin : g_bad_id
      $error("crc32_tagged_engine: ID_W must be at least 1");
   end
   if (DATA_W > CRC_W) begin : g_bad_dw
      $error("crc32_tagged_engine: DATA_W must not exceed CRC_W");
   end

   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] crc_base;
   logic [CRC_W-1:0] crc_nxt;
   logic [CRC_W-1:0] crc_fin;
   logic [ID_W-1:0]  id_q;
   logic [ID_W-1:0]  id_cur;
   logic             close_pkt;

   assign crc_base  = in_first ? SEED : crc_q;
   assign id_cur    = in_first ? in_id : id_q;
   assign close_pkt = in_valid & in_last;

   crc_byte_update #(.W(CRC_W), .DW(DATA_W), .POLY(POLY)) u_update (
      .crc_in  (crc_base),
      .data    (in_data),
      .crc_out (crc_nxt)
   );

   crc_finalize #(.W(CRC_W), .MODE(FIN)) u_final (
      .raw (crc_nxt),
      .fin (crc_fin)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         crc_q     <= SEED;
         id_q      <= '0;
         res_valid <= 1'b0;
         res_crc   <= '0;
         res_id    <= '0;
      end else begin
         res_valid <= close_pkt;
         if (in_valid) begin
            crc_q <= crc_nxt;
            id_q  <= id_cur;
         end
         if (close_pkt) begin
            res_crc <= crc_fin;
            res_id  <= id_cur;
         end
      end
   end

   AST_RES_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_last) |=> res_valid); // R5
   AST_RES_ONLY_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
      !(in_valid && in_last) |=> !res_valid); // R5
   AST_ID_HELD_MIDPKT: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !in_first) |=> $stable(id_q)); // R6
   AST_IDLE_NO_UPDATE: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(crc_q) && $stable(id_q))); // R8
   AST_SEED_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (crc_q == SEED && !res_valid)); // R9
   AST_SINGLE_BYTE_ID: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_first && in_last) |=> (res_id == $past(in_id))); // R7
endmodule

// File: tb/crc32_tagged_engine_bench.sv
module crc32_tagged_engine_bench;
   localparam int ID_W = 8;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            in_valid = 1'b0;
   logic            in_first = 1'b0;
   logic            in_last  = 1'b0;
   logic [7:0]      in_data  = 8'h00;
   logic [ID_W-1:0] in_id    = '0;
   logic            res_valid;
   logic [31:0]     res_crc;
   logic [ID_W-1:0] res_id;

   crc32_tagged_engine #(.ID_W(ID_W)) u_crc32_tagged_engine (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
      .in_last(in_last), .in_data(in_data), .in_id(in_id),
      .res_valid(res_valid), .res_crc(res_crc), .res_id(res_id)
   );

   always #5 clk = ~clk;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   bit finished = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   logic [7:0]      pkt     [0:31];
   logic [31:0]     got_crc [0:15];
   logic [ID_W-1:0] got_id  [0:15];
   int              got_cyc [0:15];
   int              got_n = 0;
   int              last_cyc;

   always @(negedge clk) begin
      if (res_valid && got_n < 16) begin
         got_crc[got_n] = res_crc;
         got_id[got_n]  = res_id;
         got_cyc[got_n] = cyc;
         got_n = got_n + 1;
      end
   end

   function automatic logic [31:0] model_crc(input int start, input int len);
      logic [31:0] c = 32'hFFFFFFFF;
      for (int i = 0; i < len; i++) begin
         c = c ^ {24'h0, pkt[start+i]};
         for (int b = 0; b < 8; b++)
            c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
      end
      return ~c;
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%08h exp=%08h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [7:0] d, input logic f, input logic l,
                        input logic [ID_W-1:0] id);
      @(negedge clk);
      in_valid = 1'b1; in_first = f; in_last = l; in_data = d; in_id = id;
      last_cyc = cyc;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0; in_first = 1'b1; in_last = 1'b1;
         in_data = 8'hA5 ^ 8'(i); in_id = 8'hEE;
      end
   endtask

   task automatic send(input int start, input int len, input logic [ID_W-1:0] id,
                       input bit mark_first, input int gap);
      for (int i = 0; i < len; i++) begin
         drive(pkt[start+i], mark_first && i == 0, i == len - 1,
               (i == 0) ? id : 8'h5A ^ 8'(i));
         if (gap > 0 && i != len - 1) idle(gap);
      end
   endtask

   task automatic expect_one(input string req, input logic [31:0] crc,
                             input logic [ID_W-1:0] id);
      check(got_n == 1, {req, " count"}, 32'(got_n), 32'd1);
      if (got_n >= 1) begin
         check(got_crc[0] == crc, {req, " crc"}, got_crc[0], crc);
         check(got_id[0] == id, {req, " id"}, 32'(got_id[0]), 32'(id));
         check(got_cyc[0] == last_cyc + 1, {req, " timing"},
               32'(got_cyc[0]), 32'(last_cyc + 1));
      end
   endtask

   task automatic t_reset_state();
      check(res_valid == 1'b0, "R9 res_valid in reset", 32'(res_valid), 32'd0);
      @(negedge clk); rst = 1'b0;
      idle(2);
      check(res_valid == 1'b0, "R9 res_valid after reset", 32'(res_valid), 32'd0);
      got_n = 0;
      send(0, 9, 8'h11, 1'b0, 0);
      idle(3);
      expect_one("R9 no-first after reset", 32'hCBF43926, 8'h00);
   endtask

   task automatic t_check_string();
      got_n = 0;
      send(0, 9, 8'h05, 1'b1, 0);
      idle(3);
      expect_one("R1 R2 R6 check string", 32'hCBF43926, 8'h05);
   endtask

   task automatic t_zero_byte();
      got_n = 0;
      send(9, 1, 8'h42, 1'b1, 0);
      idle(3);
      expect_one("R3 R7 zero byte", 32'hD202EF8D, 8'h42);
   endtask

   task automatic t_gaps();
      got_n = 0;
      send(0, 9, 8'h77, 1'b1, 2);
      idle(3);
      expect_one("R8 idle gaps", 32'hCBF43926, 8'h77);
   endtask

   task automatic t_back_to_back();
      int st [4] = '{10, 9, 0, 14};
      int ln [4] = '{4, 1, 9, 7};
      logic [ID_W-1:0] ids [4] = '{8'h03, 8'h09, 8'h01, 8'h07};
      int ends [4];
      got_n = 0;
      for (int p = 0; p < 4; p++) begin
         send(st[p], ln[p], ids[p], 1'b1, 0);
         ends[p] = last_cyc;
      end
      idle(3);
      check(got_n == 4, "R4 R5 b2b count", 32'(got_n), 32'd4);
      for (int p = 0; p < 4 && p < got_n; p++) begin
         logic [31:0] e = model_crc(st[p], ln[p]);
         check(got_crc[p] == e, "R4 R1 b2b crc", got_crc[p], e);
         check(got_id[p] == ids[p], "R6 b2b id", 32'(got_id[p]), 32'(ids[p]));
         check(got_cyc[p] == ends[p] + 1, "R5 b2b timing",
               32'(got_cyc[p]), 32'(ends[p] + 1));
      end
   endtask

   initial begin
      for (int i = 0; i < 9; i++) pkt[i] = 8'h31 + 8'(i);
      pkt[9] = 8'h00;
      for (int i = 10; i < 32; i++) pkt[i] = 8'(i * 37 + 3);
      check(model_crc(0, 9) == 32'hCBF43926, "R2 model self", model_crc(0, 9),
            32'hCBF43926);
      repeat (3) @(negedge clk);
      t_reset_state();
      t_check_string();
      t_zero_byte();
      t_gaps();
      t_back_to_back();
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++; bad++;
         $display("FAIL watchdog act=%08h exp=%08h", 32'(cyc), 32'd0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule